// File: doc/BRIEF.md
# Multi-Port Locked Load/Store Monitor

This block decides the outcome of load-linked / store-conditional style atomics issued by several CPU ports. Each port presents locked loads and locked stores on a valid/ready request channel. A locked load arms a token on the aligned 32-byte block that holds its address. A later locked store to that block succeeds only if it finds the token armed. The first locked store to reach the block takes the token. The pass or fail result comes back on a per-port result pin, and the CPU writes that value into a register. Ordinary loads and stores never reach this unit. Data movement, caches and the pipeline lie outside it.

Every request carries a two-bit scope. Bit 0 selects the requesting port's private table, which gives locking between threads on one CPU. Bit 1 selects the shared table, which gives locking between CPUs. With both bits set, a locked load arms both tables, and a locked store must pass in both. Each table holds a small number of entries, allocated by block tag with least-recently-loaded replacement.

Back-pressure: a port holds `req_valid` and its request fields steady until it sees `req_ready` high at a clock edge. Only one request is accepted per cycle, chosen by fixed priority with the lowest port index winning. `req_ready` is derived combinationally from the valid inputs. The result has no back-pressure: `rsp_valid` pulses for one cycle, in the cycle after acceptance, and the port must take it then.

Top module: `lock_monitor`

## Requirements
- R1: A synchronous reset clears every token and every valid entry in all tables and drives `rsp_valid` and `rsp_ok` low. Any locked store after reset fails until a locked load arms its block.
- R2: At most one `req_ready` bit is high in any cycle. It is high only for the lowest-index port whose `req_valid` is high. Ports that are not granted keep waiting.
- R3: A request accepted at a clock edge produces a one-cycle `rsp_valid` pulse on that port only, after that edge. `rsp_ok` is low whenever `rsp_valid` is low.
- R4: A locked load (`req_store`=0) arms the token of the entry covering its block in each selected table, whether or not that token was already armed.
- R5: A locked store (`req_store`=1) that finds the token armed succeeds and clears it. Any later locked store to that block fails until a new locked load arms it again.
- R6: Blocks are 32 bytes (address bits 31:5 form the tag). Two addresses in the same block share one token. Two addresses in different blocks do not.
- R7: A locked store whose block has no valid entry in a selected table fails and allocates nothing.
- R8: Scope bit 0 uses the requesting port's private table, which no other port can see. Scope bit 1 uses a single table shared by all ports.
- R9: With scope 2'b11, a locked store succeeds only if both tables hold an armed token. In every table it selects, it clears the token whether the store passes or fails.
- R10: Scope 2'b00 touches no table. A locked load with it arms nothing, and a locked store with it fails.
- R11: Each table holds 8 entries. A locked load that misses a full table evicts the entry least recently hit or allocated by a locked load. Locked stores do not refresh recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_store | input | NUM_PORTS | 1 = locked store, 0 = locked load, per port |
| req_scope | input | 2*NUM_PORTS | Scope per port: bit 0 private table, bit 1 shared table |
| req_addr | input | NUM_PORTS*ADDR_W | Byte address per port |
| rsp_valid | output | NUM_PORTS | Result pulse, one cycle after acceptance |
| rsp_ok | output | NUM_PORTS | Locked store passed (valid with rsp_valid) |

## Verification
A token left armed by mistake shows up on the very next locked store to that block as an `rsp_ok` of 1 where a fail is due. A token lost by mistake shows up as a spurious fail. Both appear one cycle after that store is accepted. A corrupted recency order stays hidden until a table is full and a miss evicts the wrong block. The bench therefore drives more than eight blocks through one table and compares every result, every cycle, against a behavioural model. Arbitration faults show up in the same cycle as the requests, on `req_ready`.

// File: rtl/lock_monitor_pkg.sv
package lock_monitor_pkg;
  // Scope bit positions inside each per-port two-bit scope field.
  localparam int SCOPE_PRIV_BIT   = 0;
  localparam int SCOPE_SHARED_BIT = 1;
  localparam int SCOPE_W          = 2;
endpackage

// File: rtl/lmon_arbiter.sv
module lmon_arbiter #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  // Fixed priority: lowest index wins.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lmon_table.sv
module lmon_table #(
  parameter int NENT = 8,
  parameter int TW   = 27,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_en,
  input  logic          op_store,
  input  logic [TW-1:0] tag,
  output logic          store_ok
);
  logic [NENT-1:0] vld_q, tok_q;
  logic [TW-1:0]   tag_q [NENT];
  logic [IW-1:0]   age_q [NENT];   // 0 = most recent; always a permutation

  logic          hit;
  logic [IW-1:0] hit_idx, victim, touch_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    victim  = '0;
    for (int i = 0; i < NENT; i++) begin
      if (vld_q[i] && tag_q[i] == tag) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
      if (age_q[i] == IW'(NENT - 1)) victim = IW'(i);
    end
  end

  assign touch_idx = hit ? hit_idx : victim;
  assign store_ok  = hit && tok_q[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      tok_q <= '0;
      for (int i = 0; i < NENT; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= IW'(i);
      end
    end else if (op_en) begin
      if (op_store) begin
        if (hit) tok_q[hit_idx] <= 1'b0;
      end else begin
        vld_q[touch_idx] <= 1'b1;
        tok_q[touch_idx] <= 1'b1;
        tag_q[touch_idx] <= tag;
        for (int i = 0; i < NENT; i++) begin
          if (IW'(i) == touch_idx)             age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  // Recency ages must remain a permutation of 0..NENT-1.
  logic [NENT-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < NENT; i++) age_seen[age_q[i]] = 1'b1;
  end

  AST_AGES_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
    &age_seen);  // R11
  AST_LOAD_ARMS_TOKEN: assert property (@(posedge clk) disable iff (rst)
    op_en && !op_store |=> tok_q[$past(touch_idx)] && vld_q[$past(touch_idx)]);  // R4
  AST_STORE_TAKES_TOKEN: assert property (@(posedge clk) disable iff (rst)
    op_en && op_store && hit |=> !tok_q[$past(hit_idx)]);  // R5
  AST_STORE_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
    op_en && op_store && !hit |=> $stable(vld_q) && $stable(tok_q));  // R7
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
  import lock_monitor_pkg::*;
#(
  parameter int NUM_PORTS  = 3,
  parameter int ADDR_W     = 32,
  parameter int NUM_ENT    = 8,
  parameter int BLK_BYTES  = 32,
  localparam int OFFW = $clog2(BLK_BYTES),
  localparam int TW   = ADDR_W - OFFW,
  localparam int PIW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          req_valid,
  output logic [NUM_PORTS-1:0]          req_ready,
  input  logic [NUM_PORTS-1:0]          req_store,
  input  logic [SCOPE_W*NUM_PORTS-1:0]  req_scope,
  input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
  output logic [NUM_PORTS-1:0]          rsp_valid,
  output logic [NUM_PORTS-1:0]          rsp_ok
);
  logic [PIW-1:0]     g_idx;
  logic               g_any;
  logic               g_store;
  logic [SCOPE_W-1:0] g_scope;
  logic [ADDR_W-1:0]  g_addr;
  logic [NUM_PORTS-1:0] priv_ok;
  logic               shared_ok;
  logic               g_ok;

  lmon_arbiter #(.N(NUM_PORTS)) u_arb (
    .req(req_valid), .gnt(req_ready), .gnt_idx(g_idx), .any(g_any)
  );

  assign g_store = req_store[g_idx];
  assign g_scope = req_scope[g_idx*SCOPE_W +: SCOPE_W];
  assign g_addr  = req_addr[g_idx*ADDR_W +: ADDR_W];

  // One private table per port, touched only when that port is granted.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_priv
    lmon_table #(.NENT(NUM_ENT), .TW(TW)) u_tab (
      .clk(clk), .rst(rst),
      .op_en(req_ready[p] && req_scope[p*SCOPE_W + SCOPE_PRIV_BIT]),
      .op_store(req_store[p]),
      .tag(req_addr[p*ADDR_W + OFFW +: TW]),
      .store_ok(priv_ok[p])
    );
  end

  lmon_table #(.NENT(NUM_ENT), .TW(TW)) u_shared (
    .clk(clk), .rst(rst),
    .op_en(g_any && g_scope[SCOPE_SHARED_BIT]),
    .op_store(g_store),
    .tag(g_addr[ADDR_W-1:OFFW]),
    .store_ok(shared_ok)
  );

  always_comb begin
    g_ok = g_store && (g_scope != '0)
        && (!g_scope[SCOPE_PRIV_BIT]   || priv_ok[g_idx])
        && (!g_scope[SCOPE_SHARED_BIT] || shared_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_ok    <= '0;
    end else begin
      rsp_valid <= req_ready;
      rsp_ok    <= req_ready & {NUM_PORTS{g_ok}};
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));  // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);  // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid));  // R3
  AST_OK_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok & ~rsp_valid) == '0);  // R3
  AST_NO_SCOPE_FAILS: assert property (@(posedge clk) disable iff (rst)
    g_any && g_scope == '0 |=> rsp_ok == '0);  // R10
endmodule

// File: tb/test_lock_monitor.sv
`timescale 1ns/1ps
module test_lock_monitor;
  localparam int NP = 3;
  localparam int AW = 32;
  localparam int NT = NP + 1;   // table NP = shared
  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    req_valid, req_ready, req_store, rsp_valid, rsp_ok;
  logic [2*NP-1:0]  req_scope;
  logic [NP*AW-1:0] req_addr;

  always #2.5 clk = ~clk;

  lock_monitor #(.NUM_PORTS(NP)) i_lock_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_scope(req_scope), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  // Drive values per port
  bit       d_v [NP];
  bit       d_st[NP];
  bit [1:0] d_sc[NP];
  int       d_ad[NP];

  // Expected result for the next sample
  bit e_rv[NP], e_ok[NP];
  int last_gnt;

  // Behavioural model: per table, a recency list (index 0 = newest)
  int m_tag [NT][NE];
  bit m_tok [NT][NE];
  int m_cnt [NT];

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(int t, int tg);
    for (int i = 0; i < m_cnt[t]; i++) if (m_tag[t][i] == tg) return i;
    return -1;
  endfunction

  function automatic void m_load(int t, int tg);
    int pos = m_find(t, tg);
    int n;
    if (pos < 0) begin
      if (m_cnt[t] == NE) m_cnt[t] = NE - 1;
      n = m_cnt[t];
      m_cnt[t] = n + 1;
    end else n = pos;
    for (int i = n; i > 0; i--) begin
      m_tag[t][i] = m_tag[t][i-1];
      m_tok[t][i] = m_tok[t][i-1];
    end
    m_tag[t][0] = tg;
    m_tok[t][0] = 1'b1;
  endfunction

  function automatic bit m_store(int t, int tg);
    int pos = m_find(t, tg);
    bit ok = 1'b0;
    if (pos >= 0) begin
      ok = m_tok[t][pos];
      m_tok[t][pos] = 1'b0;
    end
    return ok;
  endfunction

  // One cycle: check results, drive, check grant, advance model.
  task automatic step();
    int g = -1;
    bit ok, a, b;
    for (int p = 0; p < NP; p++) begin
      check(rsp_valid[p] == e_rv[p], "R3", rsp_valid[p], e_rv[p]);
      check(rsp_ok[p] == e_ok[p], cur_tag, rsp_ok[p], e_ok[p]);
    end
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = d_v[p];
      req_store[p] = d_st[p];
      req_scope[2*p +: 2] = d_sc[p];
      req_addr[AW*p +: AW] = AW'(d_ad[p]);
    end
    #1;
    for (int p = NP - 1; p >= 0; p--) if (d_v[p]) g = p;
    for (int p = 0; p < NP; p++) begin
      check(req_ready[p] == (p == g), "R2", req_ready[p], (p == g));
      e_rv[p] = (p == g);
      e_ok[p] = 1'b0;
    end
    last_gnt = g;
    if (g >= 0) begin
      int tg = d_ad[g] >>> 5;
      if (!d_st[g]) begin
        if (d_sc[g][0]) m_load(g, tg);
        if (d_sc[g][1]) m_load(NP, tg);
      end else begin
        a = d_sc[g][0] ? m_store(g, tg) : 1'b1;
        b = d_sc[g][1] ? m_store(NP, tg) : 1'b1;
        ok = (d_sc[g] != 2'b00) && a && b;
        e_ok[g] = ok;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_drive();
    for (int p = 0; p < NP; p++) begin
      d_v[p] = 0; d_st[p] = 0; d_sc[p] = 0; d_ad[p] = 0;
    end
  endtask

  // Single request on one port; returns the port's rsp_ok seen after it.
  task automatic one(input int p, input bit st, input bit [1:0] sc, input int ad,
                     input bit exp_ok, input string tag);
    cur_tag = tag;
    idle_drive();
    d_v[p] = 1; d_st[p] = st; d_sc[p] = sc; d_ad[p] = ad;
    step();
    if (st) check(rsp_ok[p] == exp_ok, tag, rsp_ok[p], exp_ok);
    idle_drive();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) m_cnt[t] = 0;
    for (int p = 0; p < NP; p++) begin e_rv[p] = 0; e_ok[p] = 0; end
    idle_drive();
    req_valid = '0; req_store = '0; req_scope = '0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(rsp_valid == '0, "R1", rsp_valid, 0);
    check(rsp_ok == '0, "R1", rsp_ok, 0);
    one(0, 1, 2'b01, 32'h40, 0, "R1");
    one(0, 1, 2'b10, 32'h40, 0, "R1");

    // R4, R5, R8 shared
    one(0, 0, 2'b10, 32'h100, 0, "R4");
    one(1, 1, 2'b10, 32'h100, 1, "R8");
    one(0, 1, 2'b10, 32'h100, 0, "R5");
    one(0, 0, 2'b10, 32'h100, 0, "R4");
    one(0, 0, 2'b10, 32'h104, 0, "R4");
    one(2, 1, 2'b10, 32'h10C, 1, "R5");
    one(2, 1, 2'b10, 32'h100, 0, "R5");

    // R6 block granularity
    one(0, 0, 2'b10, 32'h200, 0, "R6");
    one(0, 0, 2'b10, 32'h204, 0, "R6");
    one(0, 1, 2'b10, 32'h200, 1, "R6");
    one(0, 1, 2'b10, 32'h204, 0, "R6");
    one(1, 0, 2'b10, 32'h23C, 0, "R6");
    one(1, 0, 2'b10, 32'h240, 0, "R6");
    one(1, 1, 2'b10, 32'h23C, 1, "R6");
    one(1, 1, 2'b10, 32'h240, 1, "R6");

    // R7 no entry
    one(1, 1, 2'b10, 32'h9000, 0, "R7");
    one(1, 1, 2'b01, 32'h9000, 0, "R7");

    // R8 private isolation
    one(0, 0, 2'b01, 32'h300, 0, "R8");
    one(1, 1, 2'b01, 32'h300, 0, "R8");
    one(1, 1, 2'b10, 32'h300, 0, "R8");
    one(0, 1, 2'b01, 32'h300, 1, "R8");

    // R9 combined scope
    one(1, 0, 2'b11, 32'h400, 0, "R9");
    one(1, 1, 2'b01, 32'h400, 1, "R9");
    one(1, 1, 2'b10, 32'h400, 1, "R9");
    one(1, 0, 2'b11, 32'h500, 0, "R9");
    one(0, 1, 2'b10, 32'h500, 1, "R9");
    one(1, 1, 2'b11, 32'h500, 0, "R9");
    one(1, 1, 2'b01, 32'h500, 0, "R9");
    one(1, 0, 2'b01, 32'h600, 0, "R9");
    one(1, 1, 2'b11, 32'h600, 0, "R9");
    one(1, 0, 2'b11, 32'h680, 0, "R9");
    one(1, 1, 2'b11, 32'h680, 1, "R9");

    // R10 empty scope
    one(0, 0, 2'b00, 32'h700, 0, "R10");
    one(0, 1, 2'b10, 32'h700, 0, "R10");
    one(0, 0, 2'b10, 32'h720, 0, "R10");
    one(0, 1, 2'b00, 32'h720, 0, "R10");
    one(0, 1, 2'b10, 32'h720, 1, "R10");

    // R11 replacement in port 2 private table
    for (int k = 0; k < 9; k++) one(2, 0, 2'b01, 32'h1000 + 32*k, 0, "R11");
    one(2, 1, 2'b01, 32'h1000, 0, "R11");          // oldest evicted
    one(2, 1, 2'b01, 32'h1000 + 32*8, 1, "R11");
    one(2, 0, 2'b01, 32'h1000 + 32*1, 0, "R11");   // refresh block 1
    one(2, 0, 2'b01, 32'h1000 + 32*9, 0, "R11");   // evicts block 2
    one(2, 1, 2'b01, 32'h1000 + 32*2, 0, "R11");
    one(2, 1, 2'b01, 32'h1000 + 32*1, 1, "R11");
    one(2, 1, 2'b01, 32'h1000 + 32*4, 1, "R11");   // store: no refresh
    one(2, 0, 2'b01, 32'h1000 + 32*10, 0, "R11");  // evicts block 3
    one(2, 0, 2'b01, 32'h1000 + 32*11, 0, "R11");  // evicts block 4
    one(2, 1, 2'b01, 32'h1000 + 32*5, 1, "R11");

    // R2 arbitration burst: all three ports at once, held until served
    cur_tag = "R2";
    idle_drive();
    for (int p = 0; p < NP; p++) begin
      d_v[p] = 1; d_st[p] = 1; d_sc[p] = 2'b10; d_ad[p] = 32'h2000 + 64*p;
    end
    for (int r = 0; r < NP; r++) begin
      step();
      check(last_gnt == r, "R2", last_gnt, r);
      d_v[last_gnt] = 0;
    end
    idle_drive();
    step();

    // Mixed traffic, requests held until granted
    cur_tag = "R8";
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (!d_v[p] && ($urandom % 3 != 0)) begin
          d_v[p]  = 1;
          d_st[p] = $urandom % 2;
          d_sc[p] = 2'($urandom % 4);
          d_ad[p] = 32'h3000 + 32 * int'($urandom % 11) + 4 * int'($urandom % 8);
        end
      end
      step();
      if (last_gnt >= 0) d_v[last_gnt] = 0;
    end
    idle_drive();
    step();
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule